// File: doc/BRIEF.md
# Clock Output Gating Controller

This block sits between the clock sources of a clock generator and its output drivers. For every output clock it decides, in that clock's own domain, whether the output runs, is parked at a driven level, or is released to high impedance. It passes on a gated copy of the source clock and a 2-bit drive state that the analog driver stage acts on.

The decision for each output combines several inputs. The asynchronous control pins are a power-down pin, a CPU stop pin, a PCI/SRC stop pin and two clock-request pins. A software run bit for the PCI and SRC group comes from the register bank. Static configuration bits, also from the register bank, supply per-output enables, free-running marks, drive modes for the stopped and powered-down cases, and the routing of the clock-request pins onto SRC outputs.

The outputs are arranged in three groups: CPU, SRC and PCI. Each group has its own source clock, and each group synchronises the control pins in its own clock domain. A change to the gate is only ever made while the source clock is low, so an output never produces a shortened pulse when it stops or starts.

Top module: `clkgate_ctrl`

## Requirements
- R1: While `rst_n` is low, every output reports state 2'b10 (hi-Z) and every gated clock is low. The state encoding is 2'b00 for running, 2'b01 for parked and driven, and 2'b10 for hi-Z.
- R2: An output whose enable bit is 0 reports hi-Z (2'b10), whatever the pins or other bits say. Configuration bits take effect at the first falling edge of the output's clock after they change.
- R3: While power-down is high, every enabled output is stopped, including free-running ones. A CPU output reports hi-Z if its own power-down mode bit is 1 and parked otherwise. All SRC outputs follow the single shared SRC power-down mode bit in the same way. PCI outputs report parked.
- R4: While `cpu_stop_n` is low, each enabled CPU output whose free-running bit is 0 is stopped. It reports hi-Z if its own stop mode bit is 1 and parked otherwise.
- R5: While `pci_stop_n` is low or `sw_pci_run` is 0, each enabled SRC and PCI output whose free-running bit is 0 is stopped. SRC outputs report hi-Z or parked according to the shared SRC stop mode bit. PCI outputs report parked, with the clock held low.
- R6: An enabled output whose free-running bit is 1 keeps running through a CPU stop or a PCI/SRC stop.
- R7: When `src_req_sel[i]` is 1, SRC output i follows a clock-request pin: `req_a_n` for even i and `req_b_n` for odd i. While that pin is high the output reports hi-Z, even if it is free-running. Power-down takes priority over the request pin.
- R8: Each pin passes through two flip-flops clocked on the rising edge of the output's clock. A pin change that is present before rising edge k first shows in the state at the falling edge after rising edge k+1, and not earlier.
- R9: A running output's gated clock equals its source clock, and a stopped output's gated clock is low. The gate changes only while the source clock is low, so every high phase of a gated clock is a full half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_clk | input | 1 | Source clock of the CPU group |
| src_clk | input | 1 | Source clock of the SRC group |
| pci_clk | input | 1 | Source clock of the PCI group |
| pd | input | 1 | Power-down pin, active high, asynchronous |
| cpu_stop_n | input | 1 | CPU stop pin, active low, asynchronous |
| pci_stop_n | input | 1 | PCI/SRC stop pin, active low, asynchronous |
| req_a_n | input | 1 | Clock-request pin A, high withdraws the request for even SRC outputs |
| req_b_n | input | 1 | Clock-request pin B, high withdraws the request for odd SRC outputs |
| sw_pci_run | input | 1 | Software run bit for the PCI and SRC group, 0 stops |
| cpu_en | input | N_CPU | Per-output enable, CPU group |
| cpu_free | input | N_CPU | Free-running marks, CPU group |
| cpu_stop_hiz | input | N_CPU | Hi-Z (1) or parked (0) while CPU-stopped |
| cpu_pd_hiz | input | N_CPU | Hi-Z (1) or parked (0) while powered down |
| src_en | input | N_SRC | Per-output enable, SRC group |
| src_free | input | N_SRC | Free-running marks, SRC group |
| src_stop_hiz | input | 1 | Hi-Z (1) or parked (0) for stopped SRC outputs |
| src_pd_hiz | input | 1 | Hi-Z (1) or parked (0) for powered-down SRC outputs |
| src_req_sel | input | N_SRC | Places SRC output i under its clock-request pin |
| pci_en | input | N_PCI | Per-output enable, PCI group |
| pci_free | input | N_PCI | Free-running marks, PCI group |
| cpu_gclk | output | N_CPU | Gated CPU clocks |
| cpu_state | output | 2*N_CPU | Drive state of CPU output i at bits [2i+1:2i] |
| src_gclk | output | N_SRC | Gated SRC clocks |
| src_state | output | 2*N_SRC | Drive state of SRC output i at bits [2i+1:2i] |
| pci_gclk | output | N_PCI | Gated PCI clocks |
| pci_state | output | 2*N_PCI | Drive state of PCI output i at bits [2i+1:2i] |

## Verification
A pin change is applied just after a falling edge. Its result is due at the falling edge that follows the second rising edge, so the bench first samples just after that second rising edge, where the old state must still show, and then samples again just after the falling edge. A configuration change is due at the very next falling edge. A gated clock is checked one time unit after the following rising edge, when the source clock is high. A monitor measures every high phase of two gated clocks across stops and restarts to confirm that each one is a full half period.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;

    // Drive state reported for each output
    typedef enum logic [1:0] {
        DRV_RUN  = 2'b00,
        DRV_PARK = 2'b01,
        DRV_HIZ  = 2'b10
    } drive_e;

    // Bit positions inside a group's raw control vector
    localparam int CTL_PD    = 0;
    localparam int CTL_STOPN = 1;
    localparam int CTL_REQA  = 2;
    localparam int CTL_REQB  = 3;
    localparam int CTL_W     = 4;

    // Registered state of one output lane
    typedef struct packed {
        logic   gate;
        drive_e st;
    } lane_reg_t;

endpackage

// File: rtl/clkgate_sync.sv
`timescale 1ns/1ps
module clkgate_sync #(
    parameter int               WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d.s1 = din;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.s1 <= RST_VAL;
            r_q.s2 <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign dout = r_q.s2;

    // Output reproduces the input two rising edges late
    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n, 1)) |-> (dout == $past(din, 2))); // R8

endmodule

// File: rtl/clkgate_lane.sv
`timescale 1ns/1ps
module clkgate_lane
    import clkgate_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  logic   free,
    input  logic   stop_hiz,
    input  logic   pd_hiz,
    input  logic   req_ctl,
    input  logic   pd_s,
    input  logic   stop_s,
    input  logic   req_s,
    output logic   gclk,
    output drive_e st
);

    lane_reg_t r_d, r_q;

    // Priority: disable, power-down, clock request, stop, run
    always_comb begin
        r_d.gate = 1'b0;
        if (!en) begin
            r_d.st = DRV_HIZ;
        end else if (pd_s) begin
            r_d.st = pd_hiz ? DRV_HIZ : DRV_PARK;
        end else if (req_ctl && req_s) begin
            r_d.st = DRV_HIZ;
        end else if (stop_s && !free) begin
            r_d.st = stop_hiz ? DRV_HIZ : DRV_PARK;
        end else begin
            r_d.st   = DRV_RUN;
            r_d.gate = 1'b1;
        end
    end

    // Updated on the falling edge: the gate moves only while clk is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.gate <= 1'b0;
            r_q.st   <= DRV_HIZ;
        end else begin
            r_q <= r_d;
        end
    end

    assign gclk = clk & r_q.gate;
    assign st   = r_q.st;

    AST_PD_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        pd_s |-> (r_q.st != DRV_RUN)); // R3

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_s && !free && $stable(free)) |-> (r_q.st != DRV_RUN)); // R4, R5

    AST_REQ_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ctl && $stable(req_ctl) && req_s && !pd_s) |-> (r_q.st == DRV_HIZ)); // R7

    AST_FREE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (free && $stable(free) && en && $stable(en) && !pd_s
         && !req_ctl && $stable(req_ctl)) |-> (r_q.st == DRV_RUN)); // R6

endmodule

// File: rtl/clkgate_domain.sv
`timescale 1ns/1ps
module clkgate_domain
    import clkgate_pkg::*;
#(
    parameter int N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTL_W-1:0]  ctl_raw,
    input  logic [N-1:0]      en,
    input  logic [N-1:0]      free,
    input  logic [N-1:0]      stop_hiz,
    input  logic [N-1:0]      pd_hiz,
    input  logic [N-1:0]      req_sel,
    output logic [N-1:0]      gclk,
    output logic [2*N-1:0]    st
);

    // Inactive pin levels: power-down low, stop and request pins high
    localparam logic [CTL_W-1:0] CTL_IDLE = 4'b1110;

    logic [CTL_W-1:0] ctl_s;
    logic             pd_s, stop_s, reqa_s, reqb_s;

    clkgate_sync #(
        .WIDTH   (CTL_W),
        .RST_VAL (CTL_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ctl_raw),
        .dout  (ctl_s)
    );

    assign pd_s   = ctl_s[CTL_PD];
    assign stop_s = !ctl_s[CTL_STOPN];
    assign reqa_s = ctl_s[CTL_REQA];
    assign reqb_s = ctl_s[CTL_REQB];

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic   req_i;
        drive_e st_i;

        if (i % 2 == 0) begin : g_even
            assign req_i = reqa_s;
        end else begin : g_odd
            assign req_i = reqb_s;
        end

        clkgate_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en[i]),
            .free     (free[i]),
            .stop_hiz (stop_hiz[i]),
            .pd_hiz   (pd_hiz[i]),
            .req_ctl  (req_sel[i]),
            .pd_s     (pd_s),
            .stop_s   (stop_s),
            .req_s    (req_i),
            .gclk     (gclk[i]),
            .st       (st_i)
        );

        assign st[2*i +: 2] = st_i;
    end

endmodule

// File: rtl/clkgate_ctrl.sv
`timescale 1ns/1ps
module clkgate_ctrl
    import clkgate_pkg::*;
#(
    parameter int N_CPU = 3,
    parameter int N_SRC = 8,
    parameter int N_PCI = 6
) (
    input  logic               rst_n,
    input  logic               cpu_clk,
    input  logic               src_clk,
    input  logic               pci_clk,
    input  logic               pd,
    input  logic               cpu_stop_n,
    input  logic               pci_stop_n,
    input  logic               req_a_n,
    input  logic               req_b_n,
    input  logic               sw_pci_run,
    input  logic [N_CPU-1:0]   cpu_en,
    input  logic [N_CPU-1:0]   cpu_free,
    input  logic [N_CPU-1:0]   cpu_stop_hiz,
    input  logic [N_CPU-1:0]   cpu_pd_hiz,
    input  logic [N_SRC-1:0]   src_en,
    input  logic [N_SRC-1:0]   src_free,
    input  logic               src_stop_hiz,
    input  logic               src_pd_hiz,
    input  logic [N_SRC-1:0]   src_req_sel,
    input  logic [N_PCI-1:0]   pci_en,
    input  logic [N_PCI-1:0]   pci_free,
    output logic [N_CPU-1:0]   cpu_gclk,
    output logic [2*N_CPU-1:0] cpu_state,
    output logic [N_SRC-1:0]   src_gclk,
    output logic [2*N_SRC-1:0] src_state,
    output logic [N_PCI-1:0]   pci_gclk,
    output logic [2*N_PCI-1:0] pci_state
);

    // Pin and software stop share one synchroniser per domain
    logic             grp_stop_n;
    logic [CTL_W-1:0] cpu_ctl, src_ctl, pci_ctl;

    assign grp_stop_n = pci_stop_n & sw_pci_run;

    assign cpu_ctl = {1'b1,    1'b1,    cpu_stop_n, pd};
    assign src_ctl = {req_b_n, req_a_n, grp_stop_n, pd};
    assign pci_ctl = {1'b1,    1'b1,    grp_stop_n, pd};

    clkgate_domain #(.N(N_CPU)) u_cpu (
        .clk      (cpu_clk),
        .rst_n    (rst_n),
        .ctl_raw  (cpu_ctl),
        .en       (cpu_en),
        .free     (cpu_free),
        .stop_hiz (cpu_stop_hiz),
        .pd_hiz   (cpu_pd_hiz),
        .req_sel  ({N_CPU{1'b0}}),
        .gclk     (cpu_gclk),
        .st       (cpu_state)
    );

    clkgate_domain #(.N(N_SRC)) u_src (
        .clk      (src_clk),
        .rst_n    (rst_n),
        .ctl_raw  (src_ctl),
        .en       (src_en),
        .free     (src_free),
        .stop_hiz ({N_SRC{src_stop_hiz}}),
        .pd_hiz   ({N_SRC{src_pd_hiz}}),
        .req_sel  (src_req_sel),
        .gclk     (src_gclk),
        .st       (src_state)
    );

    // Single-ended group: always parked low when stopped
    clkgate_domain #(.N(N_PCI)) u_pci (
        .clk      (pci_clk),
        .rst_n    (rst_n),
        .ctl_raw  (pci_ctl),
        .en       (pci_en),
        .free     (pci_free),
        .stop_hiz ({N_PCI{1'b0}}),
        .pd_hiz   ({N_PCI{1'b0}}),
        .req_sel  ({N_PCI{1'b0}}),
        .gclk     (pci_gclk),
        .st       (pci_state)
    );

endmodule

// File: tb/clkgate_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkgate_ctrl_tb_top;

    localparam int  CLK_PERIOD = 10;
    localparam int  NC = 3;
    localparam int  NS = 8;
    localparam int  NP = 6;

    logic clk = 1'b0;
    logic rst_n;
    logic pd, cpu_stop_n, pci_stop_n, req_a_n, req_b_n, sw_pci_run;
    logic [NC-1:0] cpu_en, cpu_free, cpu_stop_hiz, cpu_pd_hiz;
    logic [NS-1:0] src_en, src_free, src_req_sel;
    logic          src_stop_hiz, src_pd_hiz;
    logic [NP-1:0] pci_en, pci_free;
    logic [NC-1:0]   cpu_gclk;
    logic [2*NC-1:0] cpu_state;
    logic [NS-1:0]   src_gclk;
    logic [2*NS-1:0] src_state;
    logic [NP-1:0]   pci_gclk;
    logic [2*NP-1:0] pci_state;

    int checks   = 0;
    int failures = 0;
    int glitch_err = 0;
    int pulses   = 0;
    realtime rise4 = 0.0;
    realtime rise0 = 0.0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkgate_ctrl #(.N_CPU(NC), .N_SRC(NS), .N_PCI(NP)) dut_i (
        .rst_n(rst_n), .cpu_clk(clk), .src_clk(clk), .pci_clk(clk),
        .pd(pd), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .req_a_n(req_a_n), .req_b_n(req_b_n), .sw_pci_run(sw_pci_run),
        .cpu_en(cpu_en), .cpu_free(cpu_free), .cpu_stop_hiz(cpu_stop_hiz),
        .cpu_pd_hiz(cpu_pd_hiz), .src_en(src_en), .src_free(src_free),
        .src_stop_hiz(src_stop_hiz), .src_pd_hiz(src_pd_hiz),
        .src_req_sel(src_req_sel), .pci_en(pci_en), .pci_free(pci_free),
        .cpu_gclk(cpu_gclk), .cpu_state(cpu_state), .src_gclk(src_gclk),
        .src_state(src_state), .pci_gclk(pci_gclk), .pci_state(pci_state)
    );

    // R9 monitor: every high phase of a gated clock is a full half period
    always @(posedge src_gclk[4]) begin
        rise4 = $realtime;
        if (clk !== 1'b1) glitch_err++;
    end
    always @(negedge src_gclk[4]) begin
        pulses++;
        if ($realtime - rise4 != CLK_PERIOD / 2.0) glitch_err++;
    end
    always @(posedge src_gclk[0]) begin
        rise0 = $realtime;
        if (clk !== 1'b1) glitch_err++;
    end
    always @(negedge src_gclk[0]) begin
        if ($realtime - rise0 != CLK_PERIOD / 2.0) glitch_err++;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Expected state from the requirement priority (R2, R3, R7, R4/R5, R6)
    function automatic logic [1:0] model(input logic en, input logic free,
        input logic stop, input logic shz, input logic pdn, input logic phz,
        input logic rc, input logic rq);
        if (!en)           return 2'b10;
        if (pdn)           return phz ? 2'b10 : 2'b01;
        if (rc && rq)      return 2'b10;
        if (stop && !free) return shz ? 2'b10 : 2'b01;
        return 2'b00;
    endfunction

    // Pin change applied after a falling edge: due at falling edge after 2nd rise (R8)
    task automatic wait_pin();
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic wait_cfg();
        @(negedge clk);
        #1;
    endtask

    // Compare every lane state now, then gated clocks during the next high phase
    task automatic check_all(input string req);
        logic [NC-1:0] cr;
        logic [NS-1:0] sr;
        logic [NP-1:0] pr;
        logic          grp_stop;
        grp_stop = !pci_stop_n || !sw_pci_run;
        for (int i = 0; i < NC; i++) begin
            logic [1:0] e;
            e = model(cpu_en[i], cpu_free[i], !cpu_stop_n, cpu_stop_hiz[i],
                      pd, cpu_pd_hiz[i], 1'b0, 1'b0);
            cr[i] = (e == 2'b00);
            chk(req, $sformatf("cpu_state[%0d]", i), 32'(cpu_state[2*i +: 2]), 32'(e));
        end
        for (int i = 0; i < NS; i++) begin
            logic [1:0] e;
            e = model(src_en[i], src_free[i], grp_stop, src_stop_hiz, pd,
                      src_pd_hiz, src_req_sel[i], (i % 2 == 0) ? req_a_n : req_b_n);
            sr[i] = (e == 2'b00);
            chk(req, $sformatf("src_state[%0d]", i), 32'(src_state[2*i +: 2]), 32'(e));
        end
        for (int i = 0; i < NP; i++) begin
            logic [1:0] e;
            e = model(pci_en[i], pci_free[i], grp_stop, 1'b0, pd, 1'b0, 1'b0, 1'b0);
            pr[i] = (e == 2'b00);
            chk(req, $sformatf("pci_state[%0d]", i), 32'(pci_state[2*i +: 2]), 32'(e));
        end
        @(posedge clk);
        #1;
        chk("R9", "cpu_gclk high phase", 32'(cpu_gclk), 32'(cr));
        chk("R9", "src_gclk high phase", 32'(src_gclk), 32'(sr));
        chk("R9", "pci_gclk high phase", 32'(pci_gclk), 32'(pr));
        @(negedge clk);
        #1;
        chk("R9", "gated clocks low phase", 32'({cpu_gclk, src_gclk, pci_gclk}), 32'(0));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        pd = 1'b0; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        req_a_n = 1'b0; req_b_n = 1'b0; sw_pci_run = 1'b1;
        cpu_en = '1; cpu_free = '0; cpu_stop_hiz = '0; cpu_pd_hiz = '0;
        src_en = '1; src_free = '0; src_req_sel = '0;
        src_stop_hiz = 1'b0; src_pd_hiz = 1'b0;
        pci_en = '1; pci_free = '0;
        repeat (4) @(posedge clk);
        #1;
        chk("R1", "cpu_state in reset", 32'(cpu_state), 32'({NC{2'b10}}));
        chk("R1", "src_state in reset", 32'(src_state), 32'({NS{2'b10}}));
        chk("R1", "pci_state in reset", 32'(pci_state), 32'({NP{2'b10}}));
        chk("R1", "gated clocks in reset", 32'({cpu_gclk, src_gclk, pci_gclk}), 32'(0));
        @(negedge clk);
        #1;
        rst_n = 1'b1;
        wait_pin();
        check_all("R6");
    endtask

    task automatic t_cpu_stop();
        cpu_free = 3'b100;
        cpu_stop_hiz = 3'b010;
        wait_cfg();
        cpu_stop_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R8", "cpu0 before sync delay", 32'(cpu_state[1:0]), 32'(2'b00));
        @(negedge clk);
        #1;
        chk("R8", "cpu0 after sync delay", 32'(cpu_state[1:0]), 32'(2'b01));
        check_all("R4");
        chk("R6", "free cpu2 runs in cpu stop", 32'(cpu_state[5:4]), 32'(2'b00));
        cpu_stop_n = 1'b1;
        wait_pin();
        check_all("R4");
        cpu_free = '0;
        cpu_stop_hiz = '0;
        wait_cfg();
    endtask

    task automatic t_pci_stop();
        src_free = 8'b0000_0011;
        pci_free = 6'b00_0001;
        src_stop_hiz = 1'b1;
        wait_cfg();
        pci_stop_n = 1'b0;
        wait_pin();
        check_all("R5");
        chk("R6", "free src0 runs in pci stop", 32'(src_state[1:0]), 32'(2'b00));
        src_stop_hiz = 1'b0;
        wait_cfg();
        check_all("R5");
        pci_stop_n = 1'b1;
        wait_pin();
        check_all("R5");
        sw_pci_run = 1'b0;
        wait_pin();
        check_all("R5");
        chk("R5", "pci3 parked by software stop", 32'(pci_state[7:6]), 32'(2'b01));
        sw_pci_run = 1'b1;
        wait_pin();
        src_free = '0;
        pci_free = '0;
        wait_cfg();
    endtask

    task automatic t_power_down();
        cpu_pd_hiz = 3'b011;
        cpu_free = 3'b111;
        src_free = '1;
        wait_cfg();
        pd = 1'b1;
        wait_pin();
        check_all("R3");
        chk("R3", "free cpu2 parked in power-down", 32'(cpu_state[5:4]), 32'(2'b01));
        src_pd_hiz = 1'b1;
        wait_cfg();
        check_all("R3");
        // Power-down outranks the request pin
        src_pd_hiz = 1'b0;
        src_req_sel = 8'h30;
        wait_cfg();
        req_a_n = 1'b1;
        wait_pin();
        check_all("R7");
        chk("R7", "src4 parked under power-down", 32'(src_state[9:8]), 32'(2'b01));
        pd = 1'b0;
        req_a_n = 1'b0;
        wait_pin();
        check_all("R3");
        cpu_free = '0;
        src_free = '0;
        src_req_sel = '0;
        cpu_pd_hiz = '0;
        wait_cfg();
    endtask

    task automatic t_enable();
        cpu_en = 3'b101;
        src_en = 8'b1111_0111;
        pci_en = 6'b01_1111;
        wait_cfg();
        check_all("R2");
        pd = 1'b1;
        wait_pin();
        check_all("R2");
        chk("R2", "disabled cpu1 hi-Z over power-down", 32'(cpu_state[3:2]), 32'(2'b10));
        pd = 1'b0;
        wait_pin();
        cpu_en = '1;
        src_en = '1;
        pci_en = '1;
        wait_cfg();
        check_all("R2");
    endtask

    task automatic t_clock_request();
        src_req_sel = 8'h30;
        src_free = '1;
        wait_cfg();
        req_a_n = 1'b1;
        wait_pin();
        check_all("R7");
        chk("R7", "src4 hi-Z while request withdrawn", 32'(src_state[9:8]), 32'(2'b10));
        chk("R7", "src2 not routed keeps running", 32'(src_state[5:4]), 32'(2'b00));
        req_b_n = 1'b1;
        wait_pin();
        check_all("R7");
        src_req_sel = 8'h03;
        wait_cfg();
        check_all("R7");
        req_a_n = 1'b0;
        wait_pin();
        check_all("R7");
        req_b_n = 1'b0;
        wait_pin();
        check_all("R7");
        src_req_sel = '0;
        src_free = '0;
        wait_cfg();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        t_reset();
        t_cpu_stop();
        t_pci_stop();
        t_power_down();
        t_enable();
        t_clock_request();
        repeat (2) @(posedge clk);
        #1;
        chk("R9", "short gated pulses", 32'(glitch_err), 32'(0));
        chk("R9", "monitored pulses seen", 32'(pulses > 10), 32'(1));
        summary();
    end

endmodule